// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block merges four interrupt sources into one request line for the CPU: a raster source tied to the video scan-line counter, and three sound-channel sources raised by single-cycle set pulses. When the CPU runs an acknowledge cycle, the block presents an 8-bit vector that points at the highest-priority pending source. Software supplies the upper five vector bits and chooses whether channel flags are dropped by the acknowledge itself or only by an explicit write.

The raster source has two modes, chosen by a line register that is zero after reset. While that register is zero, the block raises a raster request once every 52 scan lines, counted from the frame-start pulse. While it is nonzero, the request is raised at the end of the scan line it names. The CPU may rewrite it mid-frame to obtain several raster interrupts in one frame. The end of a line is detected when the incoming scan-line counter moves away from that line's value.

The CPU reaches four write targets through a 2-bit select: 0 = raster line register, 1 = vector register, 2 = status (write-one-to-clear for the channels), 3 = mode register (bit 4 clears the raster flag). Internally, source index 0..2 are channels 0..2 and index 3 is the raster source.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The vector is {vector register bits 7:3, source code, 1'b0}; the source code is 2'b11 for raster, 2'b00 for channel 2, 2'b01 for channel 1, 2'b10 for channel 0, and 2'b00 when nothing is pending.
- R2: The source in the vector is the highest-priority pending one, with raster above channel 2, channel 2 above channel 1, and channel 1 above channel 0.
- R3: `irq_o` is high exactly while at least one source flag is pending; a flag set at a clock edge shows on `irq_o` after that edge.
- R4: The raster flag clears on an acknowledge that selects raster, or on a write to select 3 with data bit 4 = 1; a write to select 3 with bit 4 = 0 leaves it.
- R5: Writing select 2 with data bit 6, 5 or 4 = 1 clears channel 0, 1 or 2 respectively; zero bits in that write have no effect.
- R6: When vector register bit 0 is 0, an acknowledge that selects a channel clears that channel's flag; when bit 0 is 1 (its reset value) the flag stays pending.
- R7: `stat_o` bit 7 is 1 when the most recent acknowledge with a source pending selected raster and 0 when it selected a channel; bits 6, 5, 4 show the flags of channels 0, 1, 2; bits 3:0 read 0. An acknowledge with nothing pending changes nothing.
- R8: After reset no flag is pending, `irq_o` is 0, `stat_o` is 0, the vector register reads 8'h01 (so `vec_o` is 8'h00) and the raster line register is 0.
- R9: With a nonzero raster line register N, the raster flag is set at the edge where the scan-line counter leaves value N; a new value written mid-frame takes effect for later lines.
- R10: With the raster line register at 0, the raster flag is set on every 52nd scan-line advance; the frame-start pulse restarts that count without raising the flag.
- R11: A set pulse and a clear (by write or acknowledge) for the same source in one cycle leave the flag pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_num | input | 9 | Current scan-line counter from video timing |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| ch_set | input | 3 | Interrupt set pulses, bit i for channel i |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 2 | Write target select (0 line, 1 vector, 2 status, 3 mode) |
| wr_data | input | 8 | CPU write data |
| inta | input | 1 | Interrupt acknowledge strobe, one cycle |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector for the highest-priority pending source |
| stat_o | output | 8 | Status byte read by the CPU |

## Verification
The hardest situation to reach is a collision in one cycle: a set pulse for a source together with an acknowledge or write that clears the same source, with the auto-clear bit flipped between otherwise identical acknowledges. Directed steps first walk the legacy 52-line count, the programmed-line mode with a mid-frame rewrite, and each clear path. A long pseudo-random phase then drives overlapping set pulses, acknowledges, register writes and line advances, so that collisions and priority changes occur many times, and a behavioural model compares all outputs on every clock.

// File: rtl/vic_pkg.sv
// Package: shared constants for the vectored interrupt controller.
// Assumes three sound channels plus one raster source; the raster source
// takes the highest index so that "highest index wins" equals priority.
package vic_pkg;
    localparam int NUM_CH     = 3;
    localparam int NUM_SRC    = NUM_CH + 1;
    localparam int SRC_RASTER = NUM_CH;
    localparam int DATA_W     = 8;
    localparam int CODE_W     = 2;

    // Status byte layout
    localparam int STAT_LAST_RASTER = 7;
    localparam int STAT_CH0         = 6;   // channel i sits at STAT_CH0 - i
    // Mode register bit that drops the raster flag
    localparam int MODE_RCLR        = 4;
    // Vector register bit: 0 = channel flags clear on acknowledge
    localparam int VEC_NOAUTO       = 0;

    typedef enum logic [1:0] {
        SEL_LINE = 2'd0,
        SEL_VEC  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MODE = 2'd3
    } wr_sel_e;

    // Source code placed in vector bits 2:1
    function automatic logic [CODE_W-1:0] src_code(input int idx);
        if (idx == SRC_RASTER) return {CODE_W{1'b1}};
        return CODE_W'(NUM_CH - 1 - idx);
    endfunction
endpackage

// File: rtl/vic_raster_trig.sv
// Raster trigger: turns the scan-line counter into single-cycle raster
// requests. A line ends when the counter value changes. With a zero line
// register a free count of PERIOD line advances (restarted by frame start)
// raises the request; otherwise the end of the programmed line does.
// Assumes line_num changes by at most one step per clock.
module vic_raster_trig #(
    parameter int LINE_W = 9,
    parameter int RL_W   = 8,
    parameter int PERIOD = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              frame_start,
    input  logic [RL_W-1:0]   rl_val,
    output logic              fire_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              line_adv;
    logic              legacy_hit;
    logic              prog_hit;
    logic              prog_mode;

    // Detect end of a line and the two trigger conditions
    always_comb begin
        line_adv   = (line_num != line_q);
        prog_mode  = (rl_val != '0);
        legacy_hit = line_adv && !frame_start && (cnt_q == CNT_LAST);
        prog_hit   = line_adv && (line_q == LINE_W'(rl_val));
        fire_o     = prog_mode ? prog_hit : legacy_hit;
    end

    // Track previous line and the legacy line count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            cnt_q  <= '0;
        end else begin
            line_q <= line_num;
            if (frame_start)
                cnt_q <= '0;
            else if (line_adv)
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    AST_LEGACY_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST); // R10

    AST_LEGACY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/vic_flag_bank.sv
// Flag bank: one pending flag per source plus the "last acknowledge was
// raster" bit. Set pulses win over clears in the same cycle. Channel flags
// clear on acknowledge only when auto_ch_i is high; the raster flag always
// does. Assumes ack_sel_i is one-hot or zero and names a pending source.
module vic_flag_bank #(
    parameter int NSRC = vic_pkg::NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] wr_clr_i,
    input  logic            ack_i,
    input  logic [NSRC-1:0] ack_sel_i,
    input  logic            auto_ch_i,
    output logic [NSRC-1:0] pend_o,
    output logic            last_raster_o
);
    localparam int RIDX = NSRC - 1;

    logic [NSRC-1:0] clr;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic ack_may_clr;
        // Raster always drops on its acknowledge; channels only in auto mode
        assign ack_may_clr = (i == RIDX) ? 1'b1 : auto_ch_i;
        assign clr[i] = wr_clr_i[i] | (ack_i & ack_sel_i[i] & ack_may_clr);

        // Hold, set or clear this source's pending flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[i] <= 1'b0;
            else
                pend_o[i] <= set_i[i] | (pend_o[i] & ~clr[i]);
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]); // R11

        if (i < RIDX) begin : g_ch
            AST_NOAUTO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_i && ack_sel_i[i] && !auto_ch_i && !wr_clr_i[i]) |=> pend_o[i]); // R6
        end
    end

    // Record which kind of source the latest real acknowledge served
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_raster_o <= 1'b0;
        else if (ack_i && (ack_sel_i != '0))
            last_raster_o <= ack_sel_i[RIDX];
    end

    AST_ACK_DROPS_RASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_sel_i[RIDX] && !set_i[RIDX]) |=> !pend_o[RIDX]); // R4
endmodule

// File: rtl/vic_prio_enc.sv
// Priority encoder: picks the pending source with the highest index (raster
// first, then channel 2, 1, 0) and gives its one-hot select and vector code.
// Purely combinational; code is zero when nothing is pending.
module vic_prio_enc #(
    parameter int NSRC = vic_pkg::NUM_SRC
) (
    input  logic [NSRC-1:0]             pend_i,
    output logic [NSRC-1:0]             sel_o,
    output logic [vic_pkg::CODE_W-1:0]  code_o,
    output logic                        any_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_sel
        if (i == NSRC - 1) begin : g_top
            assign sel_o[i] = pend_i[i];
        end else begin : g_low
            assign sel_o[i] = pend_i[i] & ~(|pend_i[NSRC-1:i+1]);
        end
    end

    // Translate the one-hot select to the vector's source code
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NSRC; i++)
            if (sel_o[i]) code_o = vic_pkg::src_code(i);
        any_o = |pend_i;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Top: vectored interrupt controller. Holds the raster line and vector
// registers, decodes CPU writes into clears, and joins the raster trigger,
// flag bank and priority encoder. The vector is combinational from the
// current flags; the CPU samples it during its acknowledge strobe.
module vec_irq_ctrl #(
    parameter int LINE_W = 9,
    parameter int PERIOD = 52
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINE_W-1:0]           line_num,
    input  logic                        frame_start,
    input  logic [vic_pkg::NUM_CH-1:0]  ch_set,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [vic_pkg::DATA_W-1:0]  wr_data,
    input  logic                        inta,
    output logic                        irq_o,
    output logic [vic_pkg::DATA_W-1:0]  vec_o,
    output logic [vic_pkg::DATA_W-1:0]  stat_o
);
    import vic_pkg::*;

    localparam int VEC_HI_W = DATA_W - CODE_W - 1;

    logic [DATA_W-1:0]  rl_q;
    logic [DATA_W-1:0]  vec_q;
    logic [NUM_SRC-1:0] wr_clr;
    logic [NUM_SRC-1:0] set_all;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] sel;
    logic [CODE_W-1:0]  code;
    logic               any_pend;
    logic               last_raster;
    logic               raster_fire;
    wr_sel_e            wsel;

    assign wsel = wr_sel_e'(wr_addr);

    // CPU-writable line and vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q  <= '0;
            vec_q <= DATA_W'(1);
        end else if (wr_en) begin
            if (wsel == SEL_LINE) rl_q  <= wr_data;
            if (wsel == SEL_VEC)  vec_q <= wr_data;
        end
    end

    // Decode write-one-to-clear bits for every source
    always_comb begin
        wr_clr = '0;
        for (int i = 0; i < NUM_CH; i++)
            wr_clr[i] = wr_en && (wsel == SEL_STAT) && wr_data[STAT_CH0 - i];
        wr_clr[SRC_RASTER] = wr_en && (wsel == SEL_MODE) && wr_data[MODE_RCLR];
    end

    assign set_all = {raster_fire, ch_set};

    vic_raster_trig #(
        .LINE_W (LINE_W),
        .RL_W   (DATA_W),
        .PERIOD (PERIOD)
    ) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_num    (line_num),
        .frame_start (frame_start),
        .rl_val      (rl_q),
        .fire_o      (raster_fire)
    );

    vic_flag_bank #(.NSRC(NUM_SRC)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (set_all),
        .wr_clr_i      (wr_clr),
        .ack_i         (inta),
        .ack_sel_i     (sel),
        .auto_ch_i     (~vec_q[VEC_NOAUTO]),
        .pend_o        (pend),
        .last_raster_o (last_raster)
    );

    vic_prio_enc #(.NSRC(NUM_SRC)) u_prio (
        .pend_i (pend),
        .sel_o  (sel),
        .code_o (code),
        .any_o  (any_pend)
    );

    // Assemble request, vector and status outputs
    always_comb begin
        irq_o = any_pend;
        vec_o = {vec_q[DATA_W-1 -: VEC_HI_W], code, 1'b0};
        stat_o = '0;
        stat_o[STAT_LAST_RASTER] = last_raster;
        for (int i = 0; i < NUM_CH; i++)
            stat_o[STAT_CH0 - i] = pend[i];
    end

    AST_RASTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SRC_RASTER] |-> (vec_o[2:1] == 2'b11)); // R2

    AST_WRCLR_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == SEL_STAT && wr_data[STAT_CH0] && !ch_set[0]) |=> !stat_o[STAT_CH0]); // R5

    AST_IRQ_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_all != '0)); // R3
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
    localparam int LAST_LINE = 311;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] line_num = '0;
    logic       frame_start = 1'b0;
    logic [2:0] ch_set = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       inta = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic [7:0] stat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .frame_start(frame_start),
        .ch_set(ch_set), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inta(inta), .irq_o(irq_o), .vec_o(vec_o), .stat_o(stat_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [3:0] m_pend;
    bit         m_last;
    int         m_rl, m_vec, m_cnt, m_prev;

    function automatic int top_src(input logic [3:0] p);
        for (int s = 3; s >= 0; s--) if (p[s]) return s;
        return -1;
    endfunction

    always @(posedge clk) begin
        logic [3:0] clr;
        bit adv, fire;
        int src;
        if (!rst_n) begin
            m_pend = '0; m_last = 0; m_rl = 0; m_vec = 1; m_cnt = 0; m_prev = 0;
        end else begin
            adv  = (int'(line_num) != m_prev);
            fire = 0;
            if (m_rl == 0) fire = adv && !frame_start && (m_cnt == 51);
            else           fire = adv && (m_prev == m_rl);
            if (frame_start) m_cnt = 0;
            else if (adv)    m_cnt = (m_cnt == 51) ? 0 : m_cnt + 1;
            m_prev = int'(line_num);
            clr = '0;
            src = top_src(m_pend);
            if (inta && src >= 0) begin
                m_last = (src == 3);
                if (src == 3 || m_vec[0] == 0) clr[src] = 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_rl = int'(wr_data);
                    2'd1: m_vec = int'(wr_data);
                    2'd2: begin clr[0] |= wr_data[6]; clr[1] |= wr_data[5]; clr[2] |= wr_data[4]; end
                    default: clr[3] |= wr_data[4];
                endcase
            end
            m_pend = {fire, ch_set} | (m_pend & ~clr);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on every clock
    always @(negedge clk) begin
        int s;
        logic [1:0] code;
        if (rst_n && !done) begin
            s = top_src(m_pend);
            code = (s == 3) ? 2'b11 : (s >= 0) ? 2'(2 - s) : 2'b00;
            chk("R3 irq vs model", {7'd0, irq_o}, {7'd0, |m_pend});
            chk("R1 R2 vector vs model", vec_o, {m_vec[7:3], code, 1'b0});
            chk("R7 status vs model", stat_o, {m_last, m_pend[0], m_pend[1], m_pend[2], 4'b0});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step_line();
        line_num    = (line_num == LAST_LINE) ? 9'd0 : line_num + 9'd1;
        frame_start = (line_num == 9'd0);
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] v);
        ch_set = v;
        @(negedge clk);
        ch_set = '0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 irq", {7'd0, irq_o}, 8'h00);
        chk("R8 stat", stat_o, 8'h00);
        chk("R8 vec", vec_o, 8'h00);

        // R10 legacy periodic raster
        for (int k = 0; k < 51; k++) step_line();
        chk("R10 no request before 52nd line", {7'd0, irq_o}, 8'h00);
        step_line();
        chk("R10 request on 52nd line", {7'd0, irq_o}, 8'h01);
        chk("R1 raster vector", vec_o, 8'h06);
        ack();
        chk("R4 raster cleared by ack", {7'd0, irq_o}, 8'h00);
        chk("R7 last ack raster", stat_o, 8'h80);

        // R6 auto clear on, priority among channels
        wr(2'd1, 8'hA8);
        pulse(3'b111);
        chk("R5 channel flags set", stat_o, 8'hF0);
        chk("R2 channel 2 first", vec_o, 8'hA8);
        ack();
        chk("R7 last ack channel", stat_o, 8'h60);
        chk("R2 channel 1 next", vec_o, 8'hAA);
        ack();
        chk("R6 auto clear ch1", stat_o, 8'h40);
        chk("R2 channel 0 last", vec_o, 8'hAC);
        ack();
        chk("R6 auto clear ch0", {7'd0, irq_o}, 8'h00);
        ack();
        chk("R7 empty ack no change", stat_o, 8'h00);

        // R6 auto clear off, R5 write clears
        wr(2'd1, 8'hA9);
        pulse(3'b001);
        ack();
        chk("R6 no auto clear", stat_o, 8'h40);
        wr(2'd2, 8'h00);
        chk("R5 zero write keeps", stat_o, 8'h40);
        wr(2'd2, 8'h40);
        chk("R5 write one clears", stat_o, 8'h00);

        // R11 set and clear in the same cycle
        ch_set = 3'b010;
        wr(2'd2, 8'h20);
        ch_set = '0;
        chk("R11 set wins", stat_o, 8'h20);
        wr(2'd2, 8'h20);
        chk("R5 clear ch1", stat_o, 8'h00);

        // R9 programmed line
        wr(2'd0, 8'd100);
        while (line_num != 9'd100) step_line();
        chk("R9 no request during line 100", {7'd0, irq_o}, 8'h00);
        step_line();
        chk("R9 request at end of line 100", {7'd0, irq_o}, 8'h01);
        wr(2'd3, 8'h00);
        chk("R4 mode bit4 zero keeps", {7'd0, irq_o}, 8'h01);
        wr(2'd3, 8'h10);
        chk("R4 mode write clears", {7'd0, irq_o}, 8'h00);
        wr(2'd0, 8'd150);
        while (line_num != 9'd150) step_line();
        chk("R9 rewritten no early request", {7'd0, irq_o}, 8'h00);
        step_line();
        chk("R9 rewritten line fires", {7'd0, irq_o}, 8'h01);
        pulse(3'b111);
        chk("R2 raster above channels", vec_o, 8'hAE);
        ack();
        chk("R4 R7 raster ack", stat_o, 8'hF0);
        chk("R2 channel 2 after raster", vec_o, 8'hA8);
        wr(2'd2, 8'h70);
        chk("R5 clear all channels", stat_o, 8'h80);

        // Pseudo-random phase, checked against the model each clock
        r = 32'h1ACE_B00C;
        for (int k = 0; k < 4000; k++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            ch_set = {r[2] & r[3], r[4] & r[5], r[6] & r[7]};
            inta   = (r[10:8] == 3'd0);
            wr_en  = (r[13:11] == 3'd0);
            wr_addr = r[15:14];
            wr_data = r[23:16];
            if (r[24]) begin
                line_num    = (line_num == LAST_LINE) ? 9'd0 : line_num + 9'd1;
                frame_start = (line_num == 9'd0);
            end else begin
                frame_start = 1'b0;
            end
            @(negedge clk);
        end
        ch_set = '0; inta = 1'b0; wr_en = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule